// File: doc/BRIEF.md
# Three-Buffer CAN Transmit Scheduler

This block keeps up to three outgoing CAN jobs, one per transmit buffer, and decides which buffer the protocol engine sends next. Software first locks a buffer, then submits a job to it. The block picks the pending buffer of highest rank and starts a frame as soon as the bus is idle. It then follows the engine's outcome strobes: a lost arbitration, an error, or success.

A failed attempt is retried automatically unless the no-retransmit control is set. A job is cancelled by unlocking its buffer, by a failure while no-retransmit is high, or by bus-off. With the early-transmit control high, two things change. The buffer that has entered arbitration keeps being sent until it wins, even if a higher buffer becomes pending. That buffer is also unlocked automatically when it succeeds, so software can queue the next job while the current frame is still on the bus.

Frame serialization, stuffing and CRC stay in the engine. This block sees the engine only through the `start_o` strobe and the three outcome inputs.

Top module: `can_tx_sched`

## Requirements
- R1: A submit pulse sets a buffer's ready flag only if that buffer's lock flag was already set before the cycle of the submit. A submit to an unlocked buffer is ignored, and so is a submit in the same cycle as that buffer's lock-set.
- R2: With early-transmit low, the selected index `sel_idx_o` is the highest-numbered ready buffer. Buffer index 2 ranks above index 1, which ranks above index 0. `sel_valid_o` is high when any buffer is ready.
- R3: `start_o` is high in a cycle only under all of these conditions: no frame is in progress, a buffer is ready, `bus_idle_i` is high and `bus_off_i` is low. From the next cycle, `busy_o` is one-hot on the started buffer until the engine reports an outcome.
- R4: After `arb_lost_i` or `tx_err_i` with `no_retx_i` low, the job stays ready and `busy_o` clears, so the job is attempted again.
- R5: After a failure while `no_retx_i` is high, the ready flag of the failed buffer clears.
- R6: An unlock pulse clears both the lock flag and the ready flag of that buffer on the next cycle. A frame already in progress from that buffer is not aborted: `busy_o` stays high until its outcome.
- R7: While `bus_off_i` is high, all ready flags and `busy_o` are cleared on the next cycle and no frame starts. Submits made during bus-off are dropped.
- R8: `tx_ok_i` during a frame clears that buffer's ready flag and `busy_o`. If `done_ie_i` is high, `done_irq_o` is also high for exactly the next cycle.
- R9: A failure (`arb_lost_i` or `tx_err_i`) during a frame raises `err_irq_o` for exactly the next cycle if `err_ie_i` is high. If `err_ie_i` is low, `err_irq_o` stays low.
- R10: With early-transmit low, a higher buffer that becomes ready during a frame is selected for the next attempt once the current frame fails.
- R11: With early-transmit high, a buffer that has started keeps being selected after a lost arbitration, even when a higher buffer is ready.
- R12: With early-transmit high, success also clears the lock flag of the sending buffer. With early-transmit low, the lock flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_set_i | input | 3 | Per-buffer lock request pulse |
| unlock_i | input | 3 | Per-buffer unlock pulse, which also cancels the job |
| submit_i | input | 3 | Per-buffer job submit pulse |
| bus_idle_i | input | 1 | Bus is idle, so a frame may begin |
| arb_lost_i | input | 1 | Engine outcome: arbitration lost |
| tx_err_i | input | 1 | Engine outcome: transmit error |
| tx_ok_i | input | 1 | Engine outcome: frame sent successfully |
| bus_off_i | input | 1 | Node is in bus-off |
| no_retx_i | input | 1 | Disable automatic retransmission |
| early_tx_i | input | 1 | Early-transmit mode (sticky selection and auto-unlock) |
| done_ie_i | input | 1 | Enable for the transmit-done interrupt |
| err_ie_i | input | 1 | Enable for the transmit-error interrupt |
| start_o | output | 1 | Strobe to the engine: begin a frame from `sel_idx_o` |
| sel_valid_o | output | 1 | Some buffer is ready |
| sel_idx_o | output | 2 | Buffer currently chosen for the next frame |
| locked_o | output | 3 | Per-buffer lock flags |
| ready_o | output | 3 | Per-buffer pending-job flags |
| busy_o | output | 3 | Per-buffer frame-in-progress flags |
| done_irq_o | output | 1 | One-cycle transmit-done interrupt |
| err_irq_o | output | 1 | One-cycle transmit-error interrupt |

## Verification
Several properties are checked on every cycle:
- `busy_o` is one-hot or zero, and a start is always followed by a busy buffer.
- Bus-off empties `busy_o` on the next cycle, and a submit to an unlocked buffer never raises ready.
- An unlock clears lock and ready, and the done interrupt lasts a single cycle.
- A failed attempt keeps or drops its job according to no-retransmit.
- Without early-transmit, the top-ranked ready buffer is always the one selected.

Only the directed scenarios can show the sequences that span several frames. These are pre-emption between attempts, the sticky choice and auto-unlock of early-transmit, and a frame left running after its buffer is unlocked.

// File: rtl/can_tx_sched_pkg.sv
package can_tx_sched_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel #(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic [NUM_BUF-1:0] ready_i,
    input  logic               early_tx_i,
    input  logic               sticky_v_i,
    input  logic [IDX_W-1:0]   sticky_idx_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic             found;
    logic [IDX_W-1:0] best;

    // Ascending scan: the last ready buffer seen is the highest-ranked one.
    always_comb begin
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (ready_i[i]) begin
                found = 1'b1;
                best  = IDX_W'(i);
            end
        end
        if (early_tx_i && sticky_v_i && ready_i[sticky_idx_i]) begin
            best = sticky_idx_i;
        end
    end

    assign valid_o = found;
    assign idx_o   = best;
endmodule

// File: rtl/can_tx_buf.sv
module can_tx_buf (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_set_i,
    input  logic unlock_i,
    input  logic submit_i,
    input  logic job_clr_i,
    input  logic auto_unlock_i,
    input  logic bus_off_i,
    output logic lock_o,
    output logic ready_o
);
    typedef struct packed {
        logic lock;
        logic ready;
    } buf_reg_t;

    buf_reg_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (job_clr_i) begin
            buf_d.ready = 1'b0;
        end
        if (submit_i && buf_q.lock) begin
            buf_d.ready = 1'b1;
        end
        if (lock_set_i) begin
            buf_d.lock = 1'b1;
        end
        if (unlock_i || auto_unlock_i) begin
            buf_d.lock  = 1'b0;
            buf_d.ready = 1'b0;
        end
        if (bus_off_i) begin
            buf_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign lock_o  = buf_q.lock;
    assign ready_o = buf_q.ready;

    p_submit_unlocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (submit_i && !lock_o && !ready_o) |=> !ready_o);

    p_unlock_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_i |=> (!lock_o && !ready_o));
endmodule

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl
    import can_tx_sched_pkg::*;
#(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] ready_i,
    input  logic               sel_valid_i,
    input  logic [IDX_W-1:0]   sel_idx_i,
    input  logic               bus_idle_i,
    input  logic               bus_off_i,
    input  logic               arb_lost_i,
    input  logic               tx_err_i,
    input  logic               tx_ok_i,
    input  logic               no_retx_i,
    input  logic               early_tx_i,
    input  logic               done_ie_i,
    input  logic               err_ie_i,
    output logic               start_o,
    output logic [NUM_BUF-1:0] busy_o,
    output logic [IDX_W-1:0]   cur_idx_o,
    output logic [NUM_BUF-1:0] job_clr_o,
    output logic [NUM_BUF-1:0] auto_unlock_o,
    output logic               sticky_v_o,
    output logic [IDX_W-1:0]   sticky_idx_o,
    output logic               done_irq_o,
    output logic               err_irq_o
);
    typedef struct packed {
        ctrl_state_e      state;
        logic [IDX_W-1:0] cur;
        logic             sticky_v;
        logic [IDX_W-1:0] sticky_idx;
        logic             done_irq;
        logic             err_irq;
    } ctrl_reg_t;

    ctrl_reg_t ctl_d, ctl_q;
    logic      start_d;
    logic [NUM_BUF-1:0] clr_d, unl_d;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.done_irq = 1'b0;
        ctl_d.err_irq  = 1'b0;
        start_d        = 1'b0;
        clr_d          = '0;
        unl_d          = '0;
        // A cancelled sticky job loses its claim on the selector.
        if (ctl_q.sticky_v && !ready_i[ctl_q.sticky_idx]) begin
            ctl_d.sticky_v = 1'b0;
        end
        case (ctl_q.state)
            ST_IDLE: begin
                if (sel_valid_i && bus_idle_i && !bus_off_i) begin
                    start_d     = 1'b1;
                    ctl_d.state = ST_ACTIVE;
                    ctl_d.cur   = sel_idx_i;
                    if (early_tx_i) begin
                        ctl_d.sticky_v   = 1'b1;
                        ctl_d.sticky_idx = sel_idx_i;
                    end
                end
            end
            ST_ACTIVE: begin
                if (tx_ok_i) begin
                    clr_d[ctl_q.cur] = 1'b1;
                    if (early_tx_i) begin
                        unl_d[ctl_q.cur] = 1'b1;
                    end
                    ctl_d.done_irq = done_ie_i;
                    ctl_d.sticky_v = 1'b0;
                    ctl_d.state    = ST_IDLE;
                end else if (arb_lost_i || tx_err_i) begin
                    ctl_d.err_irq = err_ie_i;
                    if (no_retx_i) begin
                        clr_d[ctl_q.cur] = 1'b1;
                        ctl_d.sticky_v   = 1'b0;
                    end
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (!early_tx_i) begin
            ctl_d.sticky_v = 1'b0;
        end
        if (bus_off_i) begin
            ctl_d.state    = ST_IDLE;
            ctl_d.sticky_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, cur: '0, sticky_v: 1'b0,
                       sticky_idx: '0, done_irq: 1'b0, err_irq: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_busy
        assign busy_o[g] = (ctl_q.state == ST_ACTIVE) && (ctl_q.cur == IDX_W'(g));
    end

    assign start_o       = start_d;
    assign cur_idx_o     = ctl_q.cur;
    assign job_clr_o     = clr_d;
    assign auto_unlock_o = unl_d;
    assign sticky_v_o    = ctl_q.sticky_v;
    assign sticky_idx_o  = ctl_q.sticky_idx;
    assign done_irq_o    = ctl_q.done_irq;
    assign err_irq_o     = ctl_q.err_irq;

    p_busy_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_o));

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (busy_o != '0));

    p_bus_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_i |=> (busy_o == '0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |=> !err_irq_o);
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] lock_set_i,
    input  logic [NUM_BUF-1:0] unlock_i,
    input  logic [NUM_BUF-1:0] submit_i,
    input  logic               bus_idle_i,
    input  logic               arb_lost_i,
    input  logic               tx_err_i,
    input  logic               tx_ok_i,
    input  logic               bus_off_i,
    input  logic               no_retx_i,
    input  logic               early_tx_i,
    input  logic               done_ie_i,
    input  logic               err_ie_i,
    output logic               start_o,
    output logic               sel_valid_o,
    output logic [IDX_W-1:0]   sel_idx_o,
    output logic [NUM_BUF-1:0] locked_o,
    output logic [NUM_BUF-1:0] ready_o,
    output logic [NUM_BUF-1:0] busy_o,
    output logic               done_irq_o,
    output logic               err_irq_o
);
    logic [NUM_BUF-1:0] job_clr, auto_unlock;
    logic               sticky_v;
    logic [IDX_W-1:0]   sticky_idx, cur_idx;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        can_tx_buf u_buf (
            .clk          (clk),
            .rst_n        (rst_n),
            .lock_set_i   (lock_set_i[g]),
            .unlock_i     (unlock_i[g]),
            .submit_i     (submit_i[g]),
            .job_clr_i    (job_clr[g]),
            .auto_unlock_i(auto_unlock[g]),
            .bus_off_i    (bus_off_i),
            .lock_o       (locked_o[g]),
            .ready_o      (ready_o[g])
        );
    end

    can_tx_prio_sel #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_sel (
        .ready_i     (ready_o),
        .early_tx_i  (early_tx_i),
        .sticky_v_i  (sticky_v),
        .sticky_idx_i(sticky_idx),
        .valid_o     (sel_valid_o),
        .idx_o       (sel_idx_o)
    );

    can_tx_ctrl #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready_i      (ready_o),
        .sel_valid_i  (sel_valid_o),
        .sel_idx_i    (sel_idx_o),
        .bus_idle_i   (bus_idle_i),
        .bus_off_i    (bus_off_i),
        .arb_lost_i   (arb_lost_i),
        .tx_err_i     (tx_err_i),
        .tx_ok_i      (tx_ok_i),
        .no_retx_i    (no_retx_i),
        .early_tx_i   (early_tx_i),
        .done_ie_i    (done_ie_i),
        .err_ie_i     (err_ie_i),
        .start_o      (start_o),
        .busy_o       (busy_o),
        .cur_idx_o    (cur_idx),
        .job_clr_o    (job_clr),
        .auto_unlock_o(auto_unlock),
        .sticky_v_o   (sticky_v),
        .sticky_idx_o (sticky_idx),
        .done_irq_o   (done_irq_o),
        .err_irq_o    (err_irq_o)
    );

    p_top_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_tx_i && ready_o[NUM_BUF-1]) |-> (sel_idx_o == IDX_W'(NUM_BUF-1)));

    p_retry_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_o != '0) && (arb_lost_i || tx_err_i) && !tx_ok_i && !no_retx_i &&
         !bus_off_i && !unlock_i[cur_idx] && ready_o[cur_idx])
        |=> ready_o[$past(cur_idx)]);

    p_noretx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_o != '0) && (arb_lost_i || tx_err_i) && !tx_ok_i && no_retx_i &&
         !submit_i[cur_idx])
        |=> !ready_o[$past(cur_idx)]);
endmodule

// File: tb/can_tx_sched_tb_top.sv
module can_tx_sched_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] lock_set_i = '0, unlock_i = '0, submit_i = '0;
    logic       bus_idle_i = 1'b0, arb_lost_i = 1'b0, tx_err_i = 1'b0, tx_ok_i = 1'b0;
    logic       bus_off_i = 1'b0, no_retx_i = 1'b0, early_tx_i = 1'b0;
    logic       done_ie_i = 1'b1, err_ie_i = 1'b1;
    logic       start_o, sel_valid_o, done_irq_o, err_irq_o;
    logic [1:0] sel_idx_o;
    logic [2:0] locked_o, ready_o, busy_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_sched dut_i (
        .clk(clk), .rst_n(rst_n), .lock_set_i(lock_set_i), .unlock_i(unlock_i),
        .submit_i(submit_i), .bus_idle_i(bus_idle_i), .arb_lost_i(arb_lost_i),
        .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i), .bus_off_i(bus_off_i),
        .no_retx_i(no_retx_i), .early_tx_i(early_tx_i), .done_ie_i(done_ie_i),
        .err_ie_i(err_ie_i), .start_o(start_o), .sel_valid_o(sel_valid_o),
        .sel_idx_o(sel_idx_o), .locked_o(locked_o), .ready_o(ready_o),
        .busy_o(busy_o), .done_irq_o(done_irq_o), .err_irq_o(err_irq_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge where inputs change.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_lock(input logic [2:0] m);
        lock_set_i = m; tick(); lock_set_i = '0;
    endtask

    task automatic pulse_submit(input logic [2:0] m);
        submit_i = m; tick(); submit_i = '0;
    endtask

    task automatic t_reset();
        chk("R3", "reset busy", busy_o, 0);
        chk("R1", "reset ready", ready_o, 0);
        chk("R6", "reset locked", locked_o, 0);
        chk("R2", "reset sel_valid", sel_valid_o, 0);
        chk("R8", "reset done_irq", done_irq_o, 0);
    endtask

    task automatic t_submit_gating();
        pulse_submit(3'b001);
        chk("R1", "submit unlocked ignored", ready_o, 0);
        lock_set_i = 3'b001; submit_i = 3'b001; tick();
        lock_set_i = '0; submit_i = '0;
        chk("R1", "submit same cycle as lock ignored", ready_o, 0);
        chk("R1", "lock set", locked_o, 3'b001);
        pulse_submit(3'b001);
        chk("R1", "submit locked sets ready", ready_o, 3'b001);
        unlock_i = 3'b001; tick(); unlock_i = '0;
        chk("R6", "unlock clears ready", ready_o, 0);
        chk("R6", "unlock clears lock", locked_o, 0);
    endtask

    task automatic t_priority();
        pulse_lock(3'b111);
        pulse_submit(3'b011);
        chk("R2", "sel among 0,1", sel_idx_o, 1);
        pulse_submit(3'b111);
        #1;
        chk("R2", "sel top", sel_idx_o, 2);
        chk("R2", "sel_valid", sel_valid_o, 1);
        chk("R3", "no start while bus busy", start_o, 0);
        @(negedge clk);
        bus_idle_i = 1'b1; #1;
        chk("R3", "start when idle", start_o, 1);
        @(negedge clk);
        bus_idle_i = 1'b0;
        chk("R3", "busy on buffer 2", busy_o, 3'b100);
        chk("R3", "start single cycle", start_o, 0);
    endtask

    task automatic t_success();
        tx_ok_i = 1'b1; tick(); tx_ok_i = 1'b0;
        chk("R8", "success clears ready", ready_o, 3'b011);
        chk("R8", "busy clears", busy_o, 0);
        chk("R8", "done irq", done_irq_o, 1);
        chk("R12", "lock kept without early", locked_o, 3'b111);
        tick();
        chk("R8", "done irq one cycle", done_irq_o, 0);
    endtask

    task automatic t_retry();
        bus_idle_i = 1'b1; tick();
        chk("R3", "busy on buffer 1", busy_o, 3'b010);
        arb_lost_i = 1'b1; tick(); arb_lost_i = 1'b0;
        chk("R4", "ready kept after arb loss", ready_o, 3'b011);
        chk("R4", "busy clear after arb loss", busy_o, 0);
        chk("R9", "err irq", err_irq_o, 1);
        tick();
        chk("R4", "retried on buffer 1", busy_o, 3'b010);
        chk("R9", "err irq one cycle", err_irq_o, 0);
        err_ie_i = 1'b0; tx_err_i = 1'b1; tick(); tx_err_i = 1'b0;
        chk("R9", "err irq masked", err_irq_o, 0);
        chk("R4", "ready kept after error", ready_o, 3'b011);
        err_ie_i = 1'b1;
        tick();
        chk("R4", "retried again", busy_o, 3'b010);
    endtask

    task automatic t_noretx();
        bus_idle_i = 1'b0; no_retx_i = 1'b1; tx_err_i = 1'b1; tick();
        tx_err_i = 1'b0; no_retx_i = 1'b0;
        chk("R5", "dropped on no-retx", ready_o, 3'b001);
        chk("R5", "busy clear", busy_o, 0);
    endtask

    task automatic t_preempt();
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        chk("R3", "busy on buffer 0", busy_o, 3'b001);
        pulse_submit(3'b100);
        chk("R10", "ready both", ready_o, 3'b101);
        chk("R10", "frame not aborted", busy_o, 3'b001);
        arb_lost_i = 1'b1; tick(); arb_lost_i = 1'b0;
        chk("R10", "higher selected next", sel_idx_o, 2);
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        chk("R10", "buffer 2 sent", busy_o, 3'b100);
        tx_ok_i = 1'b1; tick(); tx_ok_i = 1'b0;
        chk("R8", "buffer 2 done", ready_o, 3'b001);
    endtask

    task automatic t_early();
        early_tx_i = 1'b1;
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        chk("R11", "busy on buffer 0", busy_o, 3'b001);
        pulse_submit(3'b100);
        arb_lost_i = 1'b1; tick(); arb_lost_i = 1'b0;
        chk("R11", "sticky selection", sel_idx_o, 0);
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        chk("R11", "buffer 0 resent", busy_o, 3'b001);
        tx_ok_i = 1'b1; tick(); tx_ok_i = 1'b0;
        chk("R12", "auto unlock", locked_o, 3'b110);
        chk("R12", "ready after success", ready_o, 3'b100);
        chk("R11", "sticky released", sel_idx_o, 2);
    endtask

    task automatic t_bus_off();
        bus_idle_i = 1'b1; tick();
        chk("R3", "busy on buffer 2", busy_o, 3'b100);
        bus_off_i = 1'b1; tick();
        chk("R7", "busy cleared", busy_o, 0);
        chk("R7", "ready cleared", ready_o, 0);
        submit_i = 3'b010; tick(); submit_i = '0; #1;
        chk("R7", "submit dropped", ready_o, 0);
        chk("R7", "no start", start_o, 0);
        @(negedge clk);
        bus_off_i = 1'b0; bus_idle_i = 1'b0; early_tx_i = 1'b0;
    endtask

    task automatic t_unlock_inflight();
        pulse_submit(3'b010);
        bus_idle_i = 1'b1; tick(); bus_idle_i = 1'b0;
        chk("R3", "busy on buffer 1", busy_o, 3'b010);
        unlock_i = 3'b010; tick(); unlock_i = '0;
        chk("R6", "ready cleared", ready_o, 0);
        chk("R6", "lock cleared", locked_o, 3'b100);
        chk("R6", "frame continues", busy_o, 3'b010);
        tx_ok_i = 1'b1; tick(); tx_ok_i = 1'b0;
        chk("R6", "frame ends", busy_o, 0);
        chk("R8", "done irq", done_irq_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_submit_gating();
        t_priority();
        t_success();
        t_retry();
        t_noretx();
        t_preempt();
        t_early();
        t_bus_off();
        t_unlock_inflight();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule